// File: doc/BRIEF.md
# Double-Buffered Vector Descriptor Store

This block holds the list of line descriptors that a scanline rasterizer walks through once per scanline. The rasterizer asks for descriptor number N by raising a read strobe with N on the number bus. That number is the RAM address, so no queue sits between the two. One clock later the store returns the unpacked fields: start point, deltas, colour, a small tag, a "shown" flag and an end-of-list flag. Each descriptor is one 64-bit word. The word is held as two 32-bit RAM halves that are read in the same cycle.

The store has two banks. The rasterizer always reads the active bank. The host loads 64-bit words into the other bank, the shadow bank. When the host asks for a commit, the banks trade places on the first cycle of the next vertical sync pulse. Because of this, no vector changes position partway through a frame, which would draw it sheared. After a swap, the host's writes go to the bank that was active until then.

Each bank tracks one more than the highest index written into it. Any read at or above that level returns an end-of-list marker. A descriptor whose visibility bit is clear reaches the rasterizer as covering no scanline, but its end-of-list bit still takes effect.

Top module: `vls_store`

## Requirements
- R1: `rd_vld` is high in exactly the cycle after a cycle with `rd_req` high, and low in every other cycle.
- R2: A read returns the descriptor stored at address `rd_num` of the bank that was active in the request cycle.
- R3: Write word layout: x in bits 9:0, y in 19:10, dx in 29:20, dy in 40:30, colour in 56:41, visible in bit 57, end-of-list in bit 58, and tag in 63:59. `rd_x`, `rd_y`, `rd_dx`, `rd_dy`, `rd_col` and `rd_tag` return these fields unchanged.
- R4: For an entry with the visible bit clear, `rd_show` is 0 and x, y, dx, dy, colour and tag all read as zero. `rd_last` still equals the stored end-of-list bit.
- R5: Host writes go only to the shadow bank. Reads do not see them until the banks swap.
- R6: The banks swap only in the cycle where `vsync` is high after being low in the previous cycle. They swap only if `commit` was high in some earlier cycle since the last swap. A commit made while `vsync` is already high waits for the next rising edge.
- R7: A swap consumes the commit request. A later sync pulse with no new commit leaves the active bank unchanged.
- R8: Each bank's fill level is one more than the highest index written into it, and it never decreases. Reading an address at or above the active bank's fill level gives `rd_show`=0, `rd_last`=1 and all field outputs zero.
- R9: After reset, bank 0 is active and both banks are empty. Every read returns the end-of-list marker.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| wr_en | input | 1 | Host write strobe, shadow bank |
| wr_addr | input | ADDR_W | Host write index |
| wr_data | input | 64 | Packed descriptor word (layout in R3) |
| commit | input | 1 | Request a bank swap at the next sync rise |
| vsync | input | 1 | Vertical sync level |
| rd_req | input | 1 | Rasterizer read strobe |
| rd_num | input | ADDR_W | Requested vector number, used as the read address |
| rd_vld | output | 1 | Read data valid, one cycle after the strobe |
| rd_x | output | 10 | Start x |
| rd_y | output | 10 | Start y |
| rd_dx | output | 10 | Delta x |
| rd_dy | output | 11 | Delta y |
| rd_col | output | 16 | Colour |
| rd_tag | output | 5 | User tag bits |
| rd_show | output | 1 | Entry is visible and lies within the fill level |
| rd_last | output | 1 | End of list |

## Verification
Full address sweeps are run against a 32-entry configuration. They read the store while it is empty, after the shadow bank has been loaded but no swap has happened, after sync pulses with and without a preceding commit, and after a commit issued while sync was already high. These cases separate a swap that is missing or early from a correct one, and show whether writes leak into the active bank. Two arithmetic descriptor patterns with different field values, visibility spacing and list lengths show that the field positions are right and that each bank is the one being read. One pattern fills only part of the bank, so the fill-level marker is exercised. The other fills every entry, so it is never triggered.

// File: rtl/vls_pkg.sv
package vls_pkg;
  localparam int XW     = 10;
  localparam int YW     = 10;
  localparam int DXW    = 10;
  localparam int DYW    = 11;
  localparam int CW     = 16;
  localparam int TAGW   = 5;
  localparam int WORD_W = 64;
  localparam int HALF_W = WORD_W / 2;

  // Packed descriptor, most significant field first.
  typedef struct packed {
    logic [TAGW-1:0] tag;
    logic            last;
    logic            vis;
    logic [CW-1:0]   col;
    logic [DYW-1:0]  dy;
    logic [DXW-1:0]  dx;
    logic [YW-1:0]   y;
    logic [XW-1:0]   x;
  } vec_t;
endpackage

// File: rtl/vls_ram_half.sv
module vls_ram_half #(
  parameter int AW = 9,
  parameter int DW = 32
) (
  input  logic          clk,
  input  logic          we,
  input  logic [AW-1:0] waddr,
  input  logic [DW-1:0] wdata,
  input  logic          re,
  input  logic [AW-1:0] raddr,
  output logic [DW-1:0] rdata
);
  localparam int DEPTH = 1 << AW;

  logic [DW-1:0] mem_q [DEPTH];
  logic [DW-1:0] rdata_q;

  always_ff @(posedge clk) begin
    if (we) begin
      mem_q[waddr] <= wdata;
    end
  end

  always_ff @(posedge clk) begin
    if (re) begin
      rdata_q <= mem_q[raddr];
    end
  end

  assign rdata = rdata_q;
endmodule

// File: rtl/vls_bank_ctrl.sv
module vls_bank_ctrl #(
  parameter int AW = 9
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          vsync,
  input  logic          commit,
  input  logic          wr_en,
  input  logic [AW-1:0] wr_addr,
  input  logic [AW-1:0] rd_num,
  output logic          act_sel,
  output logic          beyond
);
  localparam int FW = AW + 1;

  logic          vs_q, vs_d;
  logic          pend_q, pend_d;
  logic          sel_q, sel_d;
  logic [FW-1:0] fill_q [2];
  logic [FW-1:0] fill_d [2];
  logic          vs_rise, swap;
  logic [FW-1:0] wr_level;

  always_comb begin
    vs_rise  = vsync & ~vs_q;
    swap     = vs_rise & pend_q;
    vs_d     = vsync;
    sel_d    = sel_q ^ swap;
    pend_d   = (pend_q & ~swap) | commit;
    wr_level = {1'b0, wr_addr} + FW'(1);
    for (int b = 0; b < 2; b++) begin
      fill_d[b] = fill_q[b];
      if (wr_en && (b[0] == ~sel_q) && (wr_level > fill_q[b])) begin
        fill_d[b] = wr_level;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      vs_q      <= 1'b0;
      pend_q    <= 1'b0;
      sel_q     <= 1'b0;
      fill_q[0] <= '0;
      fill_q[1] <= '0;
    end else begin
      vs_q      <= vs_d;
      pend_q    <= pend_d;
      sel_q     <= sel_d;
      fill_q[0] <= fill_d[0];
      fill_q[1] <= fill_d[1];
    end
  end

  assign act_sel = sel_q;
  assign beyond  = ({1'b0, rd_num} >= fill_q[sel_q]);

  AST_SWAP_AT_SYNC_RISE: assert property (@(posedge clk) disable iff (!rst_n)
    (sel_q != $past(sel_q)) |-> $past(vsync && !vs_q && pend_q)); // R6
  AST_PENDING_CONSUMED: assert property (@(posedge clk) disable iff (!rst_n)
    (vsync && !vs_q && pend_q && !commit) |=> !pend_q); // R7
  AST_FILL0_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q[0] >= $past(fill_q[0])); // R8
  AST_FILL1_GROWS: assert property (@(posedge clk) disable iff (!rst_n)
    fill_q[1] >= $past(fill_q[1])); // R8
endmodule

// File: rtl/vls_unpack.sv
module vls_unpack
  import vls_pkg::*;
(
  input  vec_t            word,
  input  logic            beyond,
  output logic [XW-1:0]   x,
  output logic [YW-1:0]   y,
  output logic [DXW-1:0]  dx,
  output logic [DYW-1:0]  dy,
  output logic [CW-1:0]   col,
  output logic [TAGW-1:0] tag,
  output logic            show,
  output logic            last
);
  always_comb begin
    show = ~beyond & word.vis;
    last = beyond | word.last;
    x    = show ? word.x   : '0;
    y    = show ? word.y   : '0;
    dx   = show ? word.dx  : '0;
    dy   = show ? word.dy  : '0;
    col  = show ? word.col : '0;
    tag  = show ? word.tag : '0;
  end
endmodule

// File: rtl/vls_store.sv
module vls_store
  import vls_pkg::*;
#(
  parameter int ADDR_W = 9
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              wr_en,
  input  logic [ADDR_W-1:0] wr_addr,
  input  logic [63:0]       wr_data,
  input  logic              commit,
  input  logic              vsync,
  input  logic              rd_req,
  input  logic [ADDR_W-1:0] rd_num,
  output logic              rd_vld,
  output logic [9:0]        rd_x,
  output logic [9:0]        rd_y,
  output logic [9:0]        rd_dx,
  output logic [10:0]       rd_dy,
  output logic [15:0]       rd_col,
  output logic [4:0]        rd_tag,
  output logic              rd_show,
  output logic              rd_last
);
  localparam int NBANK = 2;
  localparam int NHALF = WORD_W / HALF_W;

  // reset: asynchronous assert, synchronous release
  logic rst_s1_q, rst_s2_q, rst_i_n;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rst_s1_q <= 1'b0;
      rst_s2_q <= 1'b0;
    end else begin
      rst_s1_q <= 1'b1;
      rst_s2_q <= rst_s1_q;
    end
  end
  assign rst_i_n = rst_s2_q;

  logic act_sel, beyond;

  vls_bank_ctrl #(.AW(ADDR_W)) ctrl_i (
    .clk     (clk),
    .rst_n   (rst_i_n),
    .vsync   (vsync),
    .commit  (commit),
    .wr_en   (wr_en),
    .wr_addr (wr_addr),
    .rd_num  (rd_num),
    .act_sel (act_sel),
    .beyond  (beyond)
  );

  logic [HALF_W-1:0] half_rd [NBANK][NHALF];

  for (genvar b = 0; b < NBANK; b++) begin : g_bank
    for (genvar h = 0; h < NHALF; h++) begin : g_half
      vls_ram_half #(.AW(ADDR_W), .DW(HALF_W)) ram_i (
        .clk   (clk),
        .we    (wr_en && (act_sel != b[0])),
        .waddr (wr_addr),
        .wdata (wr_data[h*HALF_W +: HALF_W]),
        .re    (rd_req),
        .raddr (rd_num),
        .rdata (half_rd[b][h])
      );
    end
  end

  // request-side state, held with the RAM output register
  logic vld_q, vld_d;
  logic sel_rd_q, sel_rd_d;
  logic beyond_q, beyond_d;

  always_comb begin
    vld_d    = rd_req;
    sel_rd_d = sel_rd_q;
    beyond_d = beyond_q;
    if (rd_req) begin
      sel_rd_d = act_sel;
      beyond_d = beyond;
    end
  end

  always_ff @(posedge clk or negedge rst_i_n) begin
    if (!rst_i_n) begin
      vld_q    <= 1'b0;
      sel_rd_q <= 1'b0;
      beyond_q <= 1'b0;
    end else begin
      vld_q    <= vld_d;
      sel_rd_q <= sel_rd_d;
      beyond_q <= beyond_d;
    end
  end

  logic [WORD_W-1:0] word_raw;
  always_comb begin
    for (int h = 0; h < NHALF; h++) begin
      word_raw[h*HALF_W +: HALF_W] = half_rd[sel_rd_q][h];
    end
  end

  vls_unpack unpack_i (
    .word   (vec_t'(word_raw)),
    .beyond (beyond_q),
    .x      (rd_x),
    .y      (rd_y),
    .dx     (rd_dx),
    .dy     (rd_dy),
    .col    (rd_col),
    .tag    (rd_tag),
    .show   (rd_show),
    .last   (rd_last)
  );

  assign rd_vld = vld_q;

  AST_VLD_AFTER_REQ: assert property (@(posedge clk) disable iff (!rst_i_n)
    rd_req |=> rd_vld); // R1
  AST_NO_VLD_WITHOUT_REQ: assert property (@(posedge clk) disable iff (!rst_i_n)
    !rd_req |=> !rd_vld); // R1
  AST_HIDDEN_BLANK: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_vld && !rd_show) |-> (rd_x == '0 && rd_y == '0 && rd_dx == '0 &&
                              rd_dy == '0 && rd_col == '0 && rd_tag == '0)); // R4
  AST_BEYOND_IS_END: assert property (@(posedge clk) disable iff (!rst_i_n)
    (rd_vld && beyond_q) |-> (rd_last && !rd_show)); // R8
endmodule

// File: tb/vls_store_tb.sv
module vls_store_tb_top;
  localparam int AW = 5;
  localparam int N  = 1 << AW;

  logic          clk = 1'b0;
  logic          rst_n = 1'b0;
  logic          wr_en = 1'b0;
  logic [AW-1:0] wr_addr = '0;
  logic [63:0]   wr_data = '0;
  logic          commit = 1'b0;
  logic          vsync = 1'b0;
  logic          rd_req = 1'b0;
  logic [AW-1:0] rd_num = '0;
  logic          rd_vld, rd_show, rd_last;
  logic [9:0]    rd_x, rd_y, rd_dx;
  logic [10:0]   rd_dy;
  logic [15:0]   rd_col;
  logic [4:0]    rd_tag;

  int checks = 0;
  int fails  = 0;
  bit done   = 1'b0;

  always #4 clk = ~clk;

  vls_store #(.ADDR_W(AW)) dut_i (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr),
    .wr_data(wr_data), .commit(commit), .vsync(vsync), .rd_req(rd_req),
    .rd_num(rd_num), .rd_vld(rd_vld), .rd_x(rd_x), .rd_y(rd_y),
    .rd_dx(rd_dx), .rd_dy(rd_dy), .rd_col(rd_col), .rd_tag(rd_tag),
    .rd_show(rd_show), .rd_last(rd_last)
  );

  // Descriptor pattern p, entry i, list length n (R3 layout)
  function automatic logic [63:0] pat(int p, int i, int n);
    logic [9:0] x, y, dx; logic [10:0] dy; logic [15:0] c; logic [4:0] t;
    logic v, l;
    if (p == 0) begin
      x = 10'((i*37 + 5) % 1024); y = 10'((i*53 + 11) % 1024);
      dx = 10'((i*7) % 1024); dy = 11'((i*91 + 3) % 2048);
      c = 16'(i*4099 + 17); t = 5'(i); v = (i % 3) != 0;
    end else begin
      x = 10'(1023 - i*29); y = 10'(i*71 + 400); dx = 10'(i*13 + 900);
      dy = 11'(2047 - i*61); c = 16'(65535 - i*997); t = 5'(i*3 + 1);
      v = (i % 4) != 1;
    end
    l = (i == n - 1);
    return {t, l, v, c, dy, dx, y, x};
  endfunction

  // Expected read result from pattern p with fill level n (R2, R4, R8)
  function automatic logic [63:0] expect_rd(int p, int i, int n);
    logic [63:0] w;
    if (i >= n) return {5'b0, 1'b1, 1'b0, 57'b0};
    w = pat(p, i, n);
    if (!w[57]) return {5'b0, w[58], 1'b0, 57'b0};
    return w;
  endfunction

  task automatic check(bit ok, string req, logic [63:0] act, logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic do_read(int i, logic [63:0] exp, string req);
    logic [63:0] obs;
    rd_req = 1'b1; rd_num = AW'(i);
    @(negedge clk);
    rd_req = 1'b0;
    obs = {rd_tag, rd_last, rd_show, rd_col, rd_dy, rd_dx, rd_y, rd_x};
    check(rd_vld === 1'b1, "R1", 64'(rd_vld), 64'd1);
    check(obs === exp, req, obs, exp);
  endtask

  // p < 0 means an empty bank: every address reads as end-of-list
  task automatic sweep(int p, int n, string req);
    for (int i = 0; i < N; i++) begin
      do_read(i, (p < 0) ? expect_rd(0, i, 0) : expect_rd(p, i, n), req);
    end
    @(negedge clk);
    check(rd_vld === 1'b0, "R1", 64'(rd_vld), 64'd0);
  endtask

  task automatic load(int p, int n);
    for (int i = 0; i < n; i++) begin
      wr_en = 1'b1; wr_addr = AW'(i); wr_data = pat(p, i, n);
      @(negedge clk);
    end
    wr_en = 1'b0;
  endtask

  task automatic pulse_commit();
    commit = 1'b1; @(negedge clk); commit = 1'b0; @(negedge clk);
  endtask

  task automatic vs_pulse();
    vsync = 1'b1; repeat (3) @(negedge clk);
    vsync = 1'b0; repeat (2) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    if (!done) begin
      fails++; checks++;
      $display("FAIL watchdog expired");
      $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    check(rd_vld === 1'b0, "R9", 64'(rd_vld), 64'd0);
    sweep(-1, 0, "R9");                     // empty store reads end-of-list

    load(0, 20);                            // into shadow bank 1
    sweep(-1, 0, "R5");                     // not visible yet
    vs_pulse();
    sweep(-1, 0, "R6");                     // sync without commit: no swap
    pulse_commit();
    sweep(-1, 0, "R6");                     // commit without sync: no swap
    vs_pulse();
    sweep(0, 20, "R3");                     // swapped: pattern 0, fill 20 (R2 R4 R8)

    load(1, N);                             // into shadow bank 0, full
    vs_pulse();
    sweep(0, 20, "R7");                     // request already consumed

    vsync = 1'b1; @(negedge clk);
    pulse_commit();                         // commit while sync already high
    sweep(0, 20, "R6");
    vsync = 1'b0; @(negedge clk);
    vs_pulse();
    sweep(1, N, "R2");                      // pattern 1 fills every entry

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule